// File: doc/BRIEF.md
# Serial Configuration Memory Read Controller

This block is the read side of a bit-serial boot memory that streams a stored configuration image into a programmable logic device after power-up. An internal byte array is walked by a byte address counter and a bit counter. The serial output presents one bit per clock, most significant bit of each byte first. One input pin does two jobs: at one level it clears both counters, and at the other level it enables the output driver. A configuration bit selects which level does which.

Several devices can be chained. The enable output of one device drives the chip-enable input of the next. When a device has shifted out its last bit, it hands the enable on and releases its own data line. The enable output then tracks the incoming chip enable. It goes back high once the shared pin reaches its reset level, and it stays high until the whole array has been read again. A simple parallel port fills the array while the device is deselected.

Top module: `scfg_reader`

## Requirements
- R1: While `nChipEn` is 0 and the output-enable level is present, each rising clock edge advances to the next bit. Bits leave each byte from bit 7 down to bit 0, and the bytes come out from address 0 upward.
- R2: A clock edge that sees the pin at its reset level returns both counters to zero, whatever `nChipEn` is. The next bit shown is bit 7 of byte 0.
- R3: `serOutEn` is 1 only when `nChipEn` is 0, the output-enable level is present and the end of the array has not been reached. `serOut` then shows the current bit in the same cycle. Otherwise `serOutEn` is 0 and `serOut` is high-impedance.
- R4: While `nChipEn` is 1 the counters hold. After `nChipEn` returns to 0, the stream resumes at the bit where it stopped.
- R5: The edge that advances past bit 0 of the last byte sets `nCascOut` to 0 if `nChipEn` is still 0. After that the counters stay at the last position until a reset.
- R6: After the end has been reached, and while the output-enable level holds, `nCascOut` equals `nChipEn` in the same cycle.
- R7: A reset level sets `nCascOut` to 1 from the next edge on. It stays 1 until the full array has been read again.
- R8: With `rstPolInvert` = 0, a low pin means reset and a high pin means output enable. With `rstPolInvert` = 1, the two levels swap.
- R9: `loadEn` writes `loadData` into `loadAddr` only while `nChipEn` is 1. A write attempted while `nChipEn` is 0 leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that advances the counters |
| nChipEn | input | 1 | Active-low chip enable |
| rstOePin | input | 1 | Combined reset / output-enable pin |
| rstPolInvert | input | 1 | Polarity select for `rstOePin` |
| loadEn | input | 1 | Preload write strobe |
| loadAddr | input | ADDR_W | Preload byte address |
| loadData | input | 8 | Preload byte value |
| serOut | output | 1 | Three-state serial data bit |
| serOutEn | output | 1 | High when `serOut` is driven |
| nCascOut | output | 1 | Active-low enable for the next device in the chain |

## Verification
Two instances are chained. The bench checks that the boundary between them is seamless: bit 7 of the second device's byte 0 must appear in the very next cycle after the first device's last bit. A design that raised the enable output one edge late would insert a gap. One that raised it one edge early would cut off the last bit. The bench pauses the chip enable in the middle of a stream and, separately, just after the hand-off. A counter that kept running while deselected would skip bits, and an enable output that did not follow `nChipEn` would leave the second device running. It also resets after the hand-off and then reads half the array, to catch an enable output that stays low after reset. Finally it checks the saturated end, the swapped polarity, and a write attempted while the device is enabled.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int BIT_W = 3;

  typedef struct packed {
    logic advance;
    logic clear;
    logic drive;
    logic load;
  } scfgStrobe_t;

  typedef enum logic {
    CASC_WAIT = 1'b0,
    CASC_PASS = 1'b1
  } cascState_t;
endpackage

// File: rtl/scfg_ctrl.sv
module scfg_ctrl
  import scfg_pkg::*;
(
  input  logic        clk,
  input  logic        nChipEn,
  input  logic        rstOePin,
  input  logic        rstPolInvert,
  input  logic        loadEn,
  input  logic        atLastBit,
  output scfgStrobe_t strb,
  output logic        nCascOut
);
  logic       oeActive;
  logic       resetLevel;
  logic       streaming;
  cascState_t cascState;

  assign oeActive   = rstOePin ^ rstPolInvert;
  assign resetLevel = ~oeActive;
  assign streaming  = ~nChipEn & oeActive & (cascState == CASC_WAIT);

  always_comb begin
    strb.clear   = resetLevel;
    strb.advance = streaming;
    strb.drive   = streaming;
    strb.load    = loadEn & nChipEn;
  end

  always_ff @(posedge clk) begin
    if (resetLevel)
      cascState <= CASC_WAIT;
    else if (streaming && atLastBit)
      cascState <= CASC_PASS;
  end

  assign nCascOut = (cascState == CASC_PASS) ? nChipEn : 1'b1;

  // R7: a reset level always re-arms the cascade as inactive
  a_r7_reset_rearms: assert property (@(posedge clk)
    resetLevel |=> (cascState == CASC_WAIT && nCascOut));

  // R5: advancing past the final bit hands the enable on
  a_r5_enter_pass: assert property (@(posedge clk) disable iff (resetLevel)
    (strb.advance && atLastBit) |=> (cascState == CASC_PASS));

  // R7: without reaching the end the cascade stays inactive
  a_r7_wait_holds: assert property (@(posedge clk) disable iff (resetLevel)
    (cascState == CASC_WAIT && !(strb.advance && atLastBit)) |=> nCascOut);
endmodule

// File: rtl/scfg_datapath.sv
module scfg_datapath
  import scfg_pkg::*;
#(
  parameter int DEPTH_BYTES = 256,
  parameter int ADDR_W      = $clog2(DEPTH_BYTES)
)(
  input  logic              clk,
  input  scfgStrobe_t       strb,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  output logic              atLastBit,
  output logic              curBit
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH_BYTES - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = '1;

  logic [7:0]        memArr [DEPTH_BYTES];
  logic [ADDR_W-1:0] addrCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [7:0]        curByte;

  always_ff @(posedge clk) begin
    if (strb.load)
      memArr[loadAddr] <= loadData;
  end

  assign atLastBit = (addrCnt == LAST_ADDR) && (bitCnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      addrCnt <= '0;
      bitCnt  <= '0;
    end else if (strb.advance && !atLastBit) begin
      bitCnt <= bitCnt + 1'b1;
      if (bitCnt == LAST_BIT)
        addrCnt <= addrCnt + 1'b1;
    end
  end

  assign curByte = memArr[addrCnt];
  assign curBit  = curByte[~bitCnt];

  // R2: the reset level zeroes both counters
  a_r2_clear_zero: assert property (@(posedge clk)
    strb.clear |=> (addrCnt == '0 && bitCnt == '0));

  // R4: no advance strobe means counters hold
  a_r4_hold: assert property (@(posedge clk) disable iff (strb.clear)
    !strb.advance |=> ($stable(addrCnt) && $stable(bitCnt)));

  // R5: the final position saturates
  a_r5_saturate: assert property (@(posedge clk) disable iff (strb.clear)
    atLastBit |=> atLastBit);
endmodule

// File: rtl/scfg_reader.sv
module scfg_reader
  import scfg_pkg::*;
#(
  parameter int DEPTH_BYTES = 256,
  parameter int ADDR_W      = $clog2(DEPTH_BYTES)
)(
  input  logic              clk,
  input  logic              nChipEn,
  input  logic              rstOePin,
  input  logic              rstPolInvert,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  output logic              serOut,
  output logic              serOutEn,
  output logic              nCascOut
);
  scfgStrobe_t strb;
  logic        atLastBit;
  logic        curBit;

  scfg_ctrl u_ctrl (
    .clk          (clk),
    .nChipEn      (nChipEn),
    .rstOePin     (rstOePin),
    .rstPolInvert (rstPolInvert),
    .loadEn       (loadEn),
    .atLastBit    (atLastBit),
    .strb         (strb),
    .nCascOut     (nCascOut)
  );

  scfg_datapath #(.DEPTH_BYTES(DEPTH_BYTES), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .strb      (strb),
    .loadAddr  (loadAddr),
    .loadData  (loadData),
    .atLastBit (atLastBit),
    .curBit    (curBit)
  );

  assign serOutEn = strb.drive;
  assign serOut   = strb.drive ? curBit : 1'bz;

  // R3: a device never drives data after it has passed the enable on
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (strb.clear)
    serOutEn |-> nCascOut);
endmodule

// File: tb/scfg_reader_tb_top.sv
`timescale 1ns/1ps
module scfg_reader_tb_top;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int NBITS = DEPTH * 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic ceA = 1'b1, pin = 1'b0, pol = 1'b0;
  logic ldEnA = 1'b0, ldEnB = 1'b0;
  logic [AW-1:0] ldAddr = '0;
  logic [7:0] ldData = '0;
  logic outA, enA, cascA, outB, enB, cascB;

  scfg_reader #(.DEPTH_BYTES(DEPTH), .ADDR_W(AW)) dut_i (
    .clk(clk), .nChipEn(ceA), .rstOePin(pin), .rstPolInvert(pol),
    .loadEn(ldEnA), .loadAddr(ldAddr), .loadData(ldData),
    .serOut(outA), .serOutEn(enA), .nCascOut(cascA));

  scfg_reader #(.DEPTH_BYTES(DEPTH), .ADDR_W(AW)) dut_b (
    .clk(clk), .nChipEn(cascA), .rstOePin(pin), .rstPolInvert(pol),
    .loadEn(ldEnB), .loadAddr(ldAddr), .loadData(ldData),
    .serOut(outB), .serOutEn(enB), .nCascOut(cascB));

  int testsRun = 0, testsFailed = 0, modelPos = 0;
  bit expQ[$];
  string curTag = "R1";
  bit finished = 1'b0;

  function automatic logic [7:0] imgByte(int chip, int a);
    return (chip == 0) ? 8'((a * 37 + 5) & 255) : 8'((a * 11 + 144) & 255);
  endfunction

  function automatic bit expBit(int p);
    logic [7:0] b;
    b = imgByte(p / NBITS, (p % NBITS) / 8);
    return b[7 - (p % 8)];
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops one expected bit per cycle from the scoreboard
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      bit e, got;
      e = expQ.pop_front();
      got = enA ? outA : outB;
      testsRun++;
      if ((enA == enB) || (got !== e)) begin
        testsFailed++;
        $display("FAIL %s bit actual=%0d expected=%0d enA=%0d enB=%0d",
                 curTag, got, e, enA, enB);
      end
    end
  end

  task automatic toEdge();
    @(posedge clk); #1;
  endtask

  // driver: pushes expected bits, waits for monitor to drain
  task automatic stream(int n, string tag);
    curTag = tag;
    for (int i = 0; i < n; i++) begin
      expQ.push_back(expBit(modelPos));
      modelPos++;
    end
    while (expQ.size() != 0) @(posedge clk);
    #1;
  endtask

  task automatic doReset(logic rstVal);
    pin = rstVal;
    toEdge();
    pin = ~rstVal;
    modelPos = 0;
  endtask

  initial begin
    // preload both devices while deselected (R9 positive path)
    for (int a = 0; a < DEPTH; a++) begin
      ldAddr = AW'(a); ldData = imgByte(0, a); ldEnA = 1'b1; toEdge(); ldEnA = 1'b0;
      ldData = imgByte(1, a); ldEnB = 1'b1; toEdge(); ldEnB = 1'b0;
    end
    @(negedge clk);
    check(!enA && !enB, "R3 reset not driven", enA + enB, 0);
    check(cascA == 1'b1, "R2 reset cascade high", cascA, 1);
    toEdge();
    pin = 1'b1; ceA = 1'b0; modelPos = 0;
    stream(10, "R8 default polarity / R1 order");

    // R4 pause mid stream
    ceA = 1'b1;
    @(negedge clk);
    check(!enA && !enB, "R3 deselected not driven", enA, 0);
    toEdge(); toEdge(); toEdge();
    ceA = 1'b0;
    stream(14, "R4 resume after pause");

    // R2 restart from byte 0
    doReset(1'b0);
    stream(20, "R2 restart");

    // R5 hand-off across the chain boundary, seamless
    stream(NBITS - 20 + 5, "R5 boundary");
    check(cascA == 1'b0, "R5 cascade low", cascA, 0);
    check(enA == 1'b0, "R3 end releases line", enA, 0);

    // R6 cascade follows chip enable
    ceA = 1'b1;
    @(negedge clk);
    check(cascA == 1'b1, "R6 follows high", cascA, 1);
    check(!enB, "R6 next device disabled", enB, 0);
    toEdge(); toEdge();
    ceA = 1'b0;
    @(negedge clk);
    check(cascA == 1'b0, "R6 follows low", cascA, 0);
    toEdge();
    // one edge passed with B enabled: it advanced by one, keep model aligned
    modelPos++;
    stream(5, "R4 second device resumes");

    // R7 reset locks cascade high until full re-read
    doReset(1'b0);
    @(negedge clk);
    check(cascA == 1'b1, "R7 high after reset", cascA, 1);
    toEdge();
    modelPos = 0;
    // sampled one edge late: A advanced one bit
    modelPos = 1;
    stream(63, "R7 partial read");
    check(cascA == 1'b1, "R7 still high mid array", cascA, 1);
    stream(NBITS - 64 + NBITS, "R1 full chain read");
    check(cascB == 1'b0, "R5 chain end", cascB, 0);
    check(!enA && !enB, "R3 both released", enA + enB, 0);
    toEdge(); toEdge(); toEdge();
    @(negedge clk);
    check(cascB == 1'b0 && !enB, "R5 saturated end", enB, 0);
    toEdge();

    // R8 inverted polarity: high is reset
    pol = 1'b1; pin = 1'b1;
    @(negedge clk);
    check(!enA, "R8 inverted reset level", enA, 0);
    toEdge();
    pin = 1'b0; modelPos = 0;
    stream(8, "R8 inverted stream");

    // R9 write while enabled is ignored
    ldAddr = '0; ldData = 8'h00; ldEnA = 1'b1; toEdge(); ldEnA = 1'b0;
    ceA = 1'b1;
    doReset(1'b1);
    ceA = 1'b0;
    stream(8, "R9 byte 0 unchanged");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule